// File: doc/BRIEF.md
# Debug Event Action Controller

This block decides what happens when the on-chip debug logic sees an event. Three event sources arrive as single-cycle pulses: a hardware breakpoint match, a software breakpoint instruction and a trace step. Each source has its own occurrence flag. A small control register selects the response through a 2-bit action code. The register also holds a history-freeze bit and an enable for an active-low external trigger pin.

The four responses are:
- halt the core into debug mode;
- freeze program-address history capture while the core keeps running;
- raise a level-1 vectored interrupt request;
- only drive the trigger pin.

Each response has its own rearm rule. Halt events rearm when debug mode is exited. Freeze events rearm on a control register write. Interrupt and trigger-only events rearm themselves after a fixed window of cycles.

A control register write clears the flags only when it is made outside debug mode. The breakpoint comparators, the history storage and the core pipeline sit outside this block. They connect through the event inputs, the halt, freeze and interrupt outputs, and the debug-exit pulse.

Top module: `dbg_evt_ctrl`

## Requirements
- R1: A pulse on `hw_bp_i`, `sw_bp_i` or `trace_i` sets its flag in `flags_o` (bit 0 hardware, bit 1 software, bit 2 trace) on the next clock edge, whatever the action code is.
- R2: With the pin-enable bit (control bit 3) at 1, `trig_no` is low exactly while any flag is set. With it at 0, `trig_no` stays high.
- R3: Action code 00 (control bits 1:0) asserts `halt_req_o` one cycle after a flag is seen. `halt_req_o` holds until a `dbg_exit_i` pulse. That exit clears all flags and releases the pin. Capture is frozen while halted.
- R4: Action code 01 keeps `halt_req_o` low and holds `capture_freeze_o` high while a flag is set. A control write made outside debug mode clears every flag on the next edge.
- R5: Action code 10 gives one single-cycle `irq_o` pulse, in the cycle the hardware or software flag first appears. `irq_vec_o` reads 0x000C. A trace event never raises `irq_o`.
- R6: Under action codes 10 and 11, a flag clears by itself 8 cycles after it is set, so the pin is low for exactly 8 cycles.
- R7: Under action codes 10 and 11, an event arriving while its flag is set restarts the 8-cycle window, so a trace source that keeps firing holds its flag and the pin low. Code 11 raises neither halt nor freeze.
- R8: The freeze control bit (control bit 2) drives `capture_freeze_o` high in the same cycle it is written to 1. It stays high until it is written to 0.
- R9: A control write made while in debug mode leaves the flags unchanged.
- R10: If a flag is pending under action code 01 and a write changes the code to 00, `halt_req_o` rises on the next cycle.
- R11: A `dbg_exit_i` pulse outside debug mode has no effect on the flags.
- R12: After reset, all flags are clear, `halt_req_o`, `capture_freeze_o` and `irq_o` are low, and `trig_no` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hw_bp_i | input | 1 | Hardware breakpoint event pulse |
| sw_bp_i | input | 1 | Software breakpoint event pulse |
| trace_i | input | 1 | Trace event pulse |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 4 | Control write data: [3] pin enable, [2] freeze, [1:0] action code |
| dbg_exit_i | input | 1 | Debug mode exit pulse from the core |
| halt_req_o | output | 1 | Core halt request / debug mode active |
| capture_freeze_o | output | 1 | Freeze program-address history capture |
| irq_o | output | 1 | Level-1 interrupt request pulse |
| irq_vec_o | output | 16 | Interrupt vector address |
| trig_no | output | 1 | Active-low external trigger pin |
| flags_o | output | 3 | Occurrence flags {trace, software, hardware} |

## Verification
Each action code is driven with a single hardware or software pulse. This shows which of halt, freeze, interrupt and pin-only follows the code. A trace pulse under the interrupt code tells a trace event apart from a breakpoint event, since only the breakpoint raises `irq_o`.

A second trace pulse inside the rearm window separates a restarted window from a fixed one. Control writes are issued both inside and outside debug mode, which separates the flag-clearing write from the flag-preserving one. An exit pulse outside debug mode and a code change from 01 to 00 with a flag pending cover the rearm corner cases.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;
  typedef enum logic [1:0] {
    EM_HALT    = 2'b00,
    EM_FREEZE  = 2'b01,
    EM_VECTOR  = 2'b10,
    EM_TRIGGER = 2'b11
  } evt_mod_e;

  typedef struct packed {
    logic     pin_en;
    logic     fifo_halt;
    evt_mod_e mod;
  } ctl_reg_t;

  localparam int unsigned NUM_EVT   = 3;
  localparam int unsigned EVT_HW    = 0;
  localparam int unsigned EVT_SW    = 1;
  localparam int unsigned EVT_TRACE = 2;
endpackage

// File: rtl/dbg_evt_ctl_reg.sv
module dbg_evt_ctl_reg
  import dbg_evt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  ctl_reg_t wdata_i,
  output ctl_reg_t ctl_o,
  output ctl_reg_t nxt_o
);
  ctl_reg_t ctl_q;

  assign nxt_o = we_i ? wdata_i : ctl_q;
  assign ctl_o = ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else         ctl_q <= nxt_o;
  end
endmodule

// File: rtl/dbg_evt_flag.sv
module dbg_evt_flag #(
  parameter int unsigned REARM_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic auto_i,
  input  logic clr_i,
  output logic flag_o,
  output logic first_o
);
  localparam int unsigned CNT_W = (REARM_CYCLES > 2) ? $clog2(REARM_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REARM_CYCLES - 1);

  logic             flag_q;
  logic [CNT_W-1:0] cnt_q;

  assign flag_o  = flag_q;
  assign first_o = evt_i & ~flag_q;

  // a new event wins over any clear and restarts the window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (evt_i) begin
      flag_q <= 1'b1;
      cnt_q  <= '0;
    end else if (clr_i) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (flag_q && auto_i) begin
      if (cnt_q == CNT_LAST) begin
        flag_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbg_evt_mode.sv
module dbg_evt_mode
  import dbg_evt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  evt_mod_e mod_nxt_i,
  input  logic     any_flag_i,
  input  logic     exit_i,
  output logic     dbg_mode_o,
  output logic     exit_ok_o
);
  logic dbg_q, dbg_d;

  assign exit_ok_o  = exit_i & dbg_q;
  assign dbg_mode_o = dbg_q;

  always_comb begin
    if (exit_ok_o) dbg_d = 1'b0;
    else           dbg_d = dbg_q | ((mod_nxt_i == EM_HALT) & any_flag_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dbg_q <= 1'b0;
    else         dbg_q <= dbg_d;
  end
endmodule

// File: rtl/dbg_evt_ctrl.sv
module dbg_evt_ctrl
  import dbg_evt_pkg::*;
#(
  parameter int unsigned REARM_CYCLES = 8,
  parameter int unsigned VEC_W        = 16,
  parameter logic [VEC_W-1:0] IRQ_VECTOR = VEC_W'(16'h000C)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hw_bp_i,
  input  logic             sw_bp_i,
  input  logic             trace_i,
  input  logic             ctl_we_i,
  input  logic [3:0]       ctl_wdata_i,
  input  logic             dbg_exit_i,
  output logic             halt_req_o,
  output logic             capture_freeze_o,
  output logic             irq_o,
  output logic [VEC_W-1:0] irq_vec_o,
  output logic             trig_no,
  output logic [NUM_EVT-1:0] flags_o
);
  ctl_reg_t           wdata, ctl_q, ctl_nxt;
  logic [NUM_EVT-1:0] evt, flags, first;
  logic               any_flag, dbg_mode, exit_ok, flag_clr, auto_rearm, irq_q;

  assign wdata = ctl_reg_t'(ctl_wdata_i);
  assign evt   = {trace_i, sw_bp_i, hw_bp_i};

  dbg_evt_ctl_reg u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctl_we_i),
    .wdata_i (wdata),
    .ctl_o   (ctl_q),
    .nxt_o   (ctl_nxt)
  );

  // user-mode writes and debug exit both rearm every event
  assign flag_clr   = (ctl_we_i & ~dbg_mode) | exit_ok;
  assign auto_rearm = (ctl_q.mod == EM_VECTOR) | (ctl_q.mod == EM_TRIGGER);

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
    dbg_evt_flag #(.REARM_CYCLES(REARM_CYCLES)) u_flag (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .evt_i   (evt[i]),
      .auto_i  (auto_rearm),
      .clr_i   (flag_clr),
      .flag_o  (flags[i]),
      .first_o (first[i])
    );
  end

  assign any_flag = |flags;

  dbg_evt_mode u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mod_nxt_i  (ctl_nxt.mod),
    .any_flag_i (any_flag),
    .exit_i     (dbg_exit_i),
    .dbg_mode_o (dbg_mode),
    .exit_ok_o  (exit_ok)
  );

  // trace never vectors
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (ctl_q.mod == EM_VECTOR) & (first[EVT_HW] | first[EVT_SW]);
  end

  assign halt_req_o       = dbg_mode;
  assign capture_freeze_o = (ctl_we_i & wdata.fifo_halt) | ctl_q.fifo_halt | dbg_mode
                          | (~ctl_q.mod[1] & any_flag);
  assign irq_o            = irq_q;
  assign irq_vec_o        = IRQ_VECTOR;
  assign trig_no          = ~(ctl_q.pin_en & any_flag);
  assign flags_o          = flags;
endmodule

// File: rtl/dbg_evt_ctrl_chk.sv
module dbg_evt_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hw_bp_i,
  input logic       sw_bp_i,
  input logic       trace_i,
  input logic       dbg_exit_i,
  input logic       halt_req_o,
  input logic       irq_o,
  input logic       trig_no,
  input logic [2:0] flags_o
);
  logic [2:0] evt;
  assign evt = {trace_i, sw_bp_i, hw_bp_i};

  // R1
  evt_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt != 3'b0) |=> ((flags_o & $past(evt)) == $past(evt)));

  // R2
  pin_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_no |-> (flags_o != 3'b0));

  // R3
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_req_o && !dbg_exit_i) |=> halt_req_o);

  // R3
  exit_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_req_o && dbg_exit_i && (evt == 3'b0)) |=> (!halt_req_o && flags_o == 3'b0));

  // R5
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R5
  irq_bp_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flags_o[0] || flags_o[1]));
endmodule

bind dbg_evt_ctrl dbg_evt_ctrl_chk u_chk (.*);

// File: tb/dbg_evt_ctrl_bench.sv
module dbg_evt_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw = 0, sw = 0, tr = 0, we = 0, ex = 0;
  logic [3:0]  wd = '0;
  logic        halt, frz, irq, trig_n;
  logic [15:0] vec;
  logic [2:0]  flags;

  int cyc = 0, errors = 0, checks = 0;
  bit done = 0;

  typedef struct {int at; logic [6:0] m; logic [6:0] v; string r;} item_t;
  item_t q[$];

  // obs: [6] halt [5] freeze [4] irq [3] trig_n [2:0] flags
  localparam logic [6:0] M_ALL = 7'h7f, M_HALT = 7'h40, M_FRZ = 7'h20,
                         M_IRQ = 7'h10, M_TRG = 7'h08, M_FLG = 7'h07;

  dbg_evt_ctrl u_dbg_evt_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .hw_bp_i(hw), .sw_bp_i(sw), .trace_i(tr),
    .ctl_we_i(we), .ctl_wdata_i(wd), .dbg_exit_i(ex),
    .halt_req_o(halt), .capture_freeze_o(frz), .irq_o(irq), .irq_vec_o(vec),
    .trig_no(trig_n), .flags_o(flags)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  always @(negedge clk) begin
    automatic logic [6:0] obs = {halt, frz, irq, trig_n, flags};
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].at == cyc) begin
        checks++;
        if ((obs & q[i].m) !== (q[i].v & q[i].m)) begin
          errors++;
          $display("FAIL %s: cyc %0d got %b expected %b (mask %b)",
                   q[i].r, cyc, obs & q[i].m, q[i].v & q[i].m, q[i].m);
        end
        q.delete(i);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic expect_at(int dt, logic [6:0] m, logic [6:0] v, string r);
    q.push_back('{cyc + dt, m, v, r});
  endtask

  task automatic wr(logic [3:0] d);
    we = 1; wd = d; tick(); we = 0;
  endtask

  task automatic pulse(int which);
    if (which == 0) hw = 1; else if (which == 1) sw = 1; else if (which == 2) tr = 1; else ex = 1;
    tick();
    hw = 0; sw = 0; tr = 0; ex = 0;
  endtask

  initial begin
    tick(2);
    rst_n = 1;
    tick();
    expect_at(0, M_ALL, 7'b0001000, "R12 reset state");
    tick(2);

    // action code 00: halt
    wr(4'b1000);
    expect_at(1, M_FLG | M_TRG | M_HALT, 7'b0000001, "R1 hw flag, R2 pin low");
    expect_at(2, M_HALT | M_FRZ, 7'b1100000, "R3 halt and freeze");
    expect_at(6, M_HALT, 7'b1000000, "R3 halt held");
    pulse(0);
    tick(6);
    expect_at(1, M_ALL, 7'b0001000, "R3 exit clears");
    pulse(3);
    tick(2);

    // action code 01: freeze
    wr(4'b1001);
    expect_at(1, M_ALL, 7'b0100010, "R4 freeze no halt");
    pulse(1);
    tick(2);
    expect_at(1, M_FLG, 7'b0000010, "R11 exit ignored");
    pulse(3);
    tick(2);
    expect_at(1, M_FLG | M_FRZ | M_TRG, 7'b0001000, "R4 user write clears");
    wr(4'b1001);
    tick(2);
    pulse(1);
    tick(2);
    expect_at(1, M_HALT | M_FLG, 7'b1000000, "R10 01->00 halts");
    wr(4'b1000);
    tick(2);
    pulse(3);
    tick(2);

    // writes inside debug mode
    pulse(0);
    tick(2);
    expect_at(1, M_FLG | M_HALT, 7'b1000001, "R9 debug write keeps flags");
    wr(4'b1000);
    tick(2);
    pulse(3);
    tick(2);

    // action code 10: vector
    wr(4'b1010);
    if (vec !== 16'h000C) begin
      errors++;
      $display("FAIL R5 vector: got %h expected 000c", vec);
    end
    checks++;
    expect_at(1, M_IRQ | M_FLG | M_TRG, 7'b0010001, "R5 irq on hw");
    expect_at(2, M_IRQ, 7'b0000000, "R5 irq single cycle");
    expect_at(8, M_FLG | M_TRG, 7'b0000001, "R6 still set at 8th cycle");
    expect_at(9, M_FLG | M_TRG, 7'b0001000, "R6 auto rearm");
    pulse(0);
    tick(10);
    expect_at(1, M_IRQ | M_FLG, 7'b0010010, "R5 irq on sw");
    pulse(1);
    tick(10);
    expect_at(1, M_IRQ | M_FLG | M_TRG, 7'b0000100, "R5 trace no irq");
    pulse(2);
    tick(10);

    // action code 11: trigger only, window restart
    wr(4'b1011);
    expect_at(1, M_ALL, 7'b0000100, "R7 trigger only");
    expect_at(9, M_FLG | M_TRG, 7'b0000100, "R7 window restarted");
    expect_at(13, M_FLG | M_TRG, 7'b0000100, "R7 still held");
    expect_at(14, M_FLG | M_TRG, 7'b0001000, "R7 clears after restart");
    pulse(2);
    tick(4);
    pulse(2);
    tick(12);

    // pin disabled
    wr(4'b0011);
    expect_at(1, M_FLG | M_TRG, 7'b0001001, "R2 pin disabled");
    pulse(0);
    tick(10);

    // freeze control bit
    expect_at(0, M_FRZ, 7'b0100000, "R8 freeze same cycle");
    expect_at(3, M_FRZ, 7'b0100000, "R8 freeze held");
    wr(4'b0111);
    tick(2);
    expect_at(1, M_FRZ, 7'b0000000, "R8 freeze released");
    wr(4'b0011);
    tick(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule